// File: doc/BRIEF.md
# Forty-Bit Free-Running Time Base

This block keeps a wide counter that software uses as a monotonic system clock. The counter never reloads and never raises an interrupt. While it is running, it advances by one on each pulse of a tick-enable input. The nominal tick rate is 983040 Hz, and the pulses are made outside this block. At the default widths the count only wraps after many days of operation.

Software sees the count through two 32-bit word registers on a simple single-cycle access port. A low word returns the least significant count bits. A high word returns the remaining count bits in its bottom byte, together with a run-control bit at bit 8. Setting that bit starts the counter, and clearing it freezes the count in place. Reading the low word captures the upper count bits in a shadow. The next high-word read returns that shadow, so a low-then-high pair yields one coherent value even when a carry crosses the boundary between the two reads.

Top module: `time_base40`

## Requirements
- R1: After reset, the count is zero, the run bit is 0, and both value registers read as zero.
- R2: While the run bit is 1, the count increases by exactly one on each clock edge where `tick` is high. It does not change on edges where `tick` is low.
- R3: While the run bit is 0, the count holds its value regardless of `tick`. Clearing the run bit does not clear the count.
- R4: A read at byte offset 0x60 returns count bits LO_W-1:0 zero-extended to 32 bits.
- R5: A read at byte offset 0x64 returns the upper count field in data bits HI_W-1:0 (HI_W = CNT_W-LO_W) and the run bit in data bit 8. All other data bits read zero.
- R6: A write at offset 0x64 sets the run bit to data bit 8. The other written bits are ignored, and writes at offset 0x60 change nothing.
- R7: A read at 0x60 captures the upper count field in a shadow. The first 0x64 read after it returns the shadow. Later 0x64 reads return the live field until the next 0x60 read.
- R8: The count wraps from all ones to zero. The carry out of the low word propagates into the upper field.
- R9: Read data is registered: it appears in the cycle after the request and holds until the next read. A read of any other offset returns zero, and writes leave the read data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-advance pulse, one clock wide per tick |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench drives two instances from the same stimulus. One uses the default widths, CNT_W=40 and LO_W=32. The other uses CNT_W=12 and LO_W=8, which puts a carry into the upper field at 256 ticks and a full wrap at 4096 ticks. With the narrow instance, the shadow coherence across a carry and the all-ones-to-zero wrap both happen within a few thousand cycles. The wide instance confirms the field layout and the zero padding at the real widths, tracking the same tick count without wrapping.

// File: rtl/time_base_pkg.sv
package time_base_pkg;
  localparam int WORD_W = 32;
  localparam int RUN_POS = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_MISC = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/time_base_counter.sv
module time_base_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o,
  output logic             adv_o
);
  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign adv_o   = tick_i & run_i;
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (adv_o) count_q <= bump(count_q);
  end

  // R2 R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> count_q == CNT_W'($past(count_q) + CNT_W'(1)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_o |=> $stable(count_q));
endmodule

// File: rtl/time_base_shadow.sv
module time_base_shadow #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_rd_i,
  input  logic            hi_rd_i,
  input  logic [HI_W-1:0] live_hi_i,
  output logic [HI_W-1:0] hi_view_o,
  output logic            pend_o
);
  logic [HI_W-1:0] shad_q;
  logic            pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q <= '0;
      pend_q <= 1'b0;
    end else if (lo_rd_i) begin
      shad_q <= live_hi_i;
      pend_q <= 1'b1;
    end else if (hi_rd_i) begin
      pend_q <= 1'b0;
    end
  end

  assign hi_view_o = pend_q ? shad_q : live_hi_i;
  assign pend_o    = pend_q;

  // R7
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_i |=> (pend_q && shad_q == $past(live_hi_i)));

  // R7
  shadow_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd_i |=> !pend_q);
endmodule

// File: rtl/time_base_regs.sv
module time_base_regs
  import time_base_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LO_OFS = 'h60,
  parameter int HI_OFS = 'h64,
  parameter int CNT_W  = 40,
  parameter int LO_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-LO_W-1:0] hi_view_i,
  output logic              run_o,
  output logic              lo_rd_o,
  output logic              hi_rd_o,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam int HI_W = CNT_W - LO_W;
  localparam logic [WORD_W-1:0] HI_MASK =
    (WORD_W'(1) << RUN_POS) | ((WORD_W'(1) << HI_W) - WORD_W'(1));

  acc_kind_e   kind;
  logic        rd_any;
  logic        hi_wr;
  logic        run_q;
  logic [WORD_W-1:0] rdata_q;

  function automatic acc_kind_e classify(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(LO_OFS))      return ACC_LO;
    else if (a == ADDR_W'(HI_OFS)) return ACC_HI;
    else                           return ACC_MISC;
  endfunction

  function automatic logic [WORD_W-1:0] pack_lo(input logic [LO_W-1:0] v);
    return WORD_W'(v);
  endfunction

  function automatic logic [WORD_W-1:0] pack_hi(input logic [HI_W-1:0] f,
                                                input logic e);
    logic [WORD_W-1:0] r;
    r = WORD_W'(f);
    r[RUN_POS] = e;
    return r;
  endfunction

  assign kind    = bus_valid ? classify(bus_addr) : ACC_NONE;
  assign rd_any  = bus_valid && !bus_write;
  assign lo_rd_o = rd_any && (kind == ACC_LO);
  assign hi_rd_o = rd_any && (kind == ACC_HI);
  assign hi_wr   = bus_valid && bus_write && (kind == ACC_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= 1'b0;
    else if (hi_wr) run_q <= bus_wdata[RUN_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_any) begin
      case (kind)
        ACC_LO:  rdata_q <= pack_lo(count_i[LO_W-1:0]);
        ACC_HI:  rdata_q <= pack_hi(hi_view_i, run_q);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign run_o     = run_q;
  assign bus_rdata = rdata_q;

  // R6
  run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> run_q == $past(bus_wdata[RUN_POS]));

  // R6
  run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(run_q));

  // R5
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd_o |=> (bus_rdata & ~HI_MASK) == '0);

  // R4
  lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_o |=> (bus_rdata >> LO_W) == '0);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(bus_rdata));
endmodule

// File: rtl/time_base40.sv
module time_base40
  import time_base_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LO_OFS = 'h60,
  parameter int HI_OFS = 'h64,
  parameter int CNT_W  = 40,
  parameter int LO_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int HI_W = CNT_W - LO_W;

  logic [CNT_W-1:0] count;
  logic             adv;
  logic             run;
  logic             lo_rd;
  logic             hi_rd;
  logic [HI_W-1:0]  hi_view;
  logic             shad_pend;

  time_base_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .run_i   (run),
    .count_o (count),
    .adv_o   (adv)
  );

  time_base_shadow #(.HI_W(HI_W)) u_shad (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_rd_i   (lo_rd),
    .hi_rd_i   (hi_rd),
    .live_hi_i (count[CNT_W-1:LO_W]),
    .hi_view_o (hi_view),
    .pend_o    (shad_pend)
  );

  time_base_regs #(
    .ADDR_W (ADDR_W),
    .LO_OFS (LO_OFS),
    .HI_OFS (HI_OFS),
    .CNT_W  (CNT_W),
    .LO_W   (LO_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_i   (count),
    .hi_view_i (hi_view),
    .run_o     (run),
    .lo_rd_o   (lo_rd),
    .hi_rd_o   (hi_rd),
    .bus_rdata (bus_rdata)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count == '0 && !run && !shad_pend));

  // R2 R3
  adv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (run && tick));
endmodule

// File: tb/test_time_base40.sv
module test_time_base40;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_big;
  logic [31:0] rd_small;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint unsigned cnt_m = 0;
  bit   run_m = 1'b0;
  bit   pend_m = 1'b0;
  longint unsigned shad_big_m = 0;
  longint unsigned shad_small_m = 0;

  always #5 clk = ~clk;

  time_base40 i_time_base40 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_big)
  );

  time_base40 #(.CNT_W(12), .LO_W(8)) i_time_base40_small (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_small)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (a == 8'h64) run_m = d[8];
  endtask

  task automatic do_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    if (run_m) cnt_m = cnt_m + longint'(n);
  endtask

  task automatic read_chk(input logic [7:0] a, input string req);
    logic [31:0] eb, es;
    longint unsigned hb, hs;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    hb = (cnt_m >> 32) & 64'hFF;
    hs = (cnt_m >> 8) & 64'hF;
    if (a == 8'h60) begin
      eb = 32'(cnt_m & 64'hFFFF_FFFF);
      es = 32'(cnt_m & 64'hFF);
      pend_m = 1'b1; shad_big_m = hb; shad_small_m = hs;
    end else if (a == 8'h64) begin
      eb = 32'(pend_m ? shad_big_m : hb) | (32'(run_m) << 8);
      es = 32'(pend_m ? shad_small_m : hs) | (32'(run_m) << 8);
      pend_m = 1'b0;
    end else begin
      eb = '0; es = '0;
    end
    check({req, " wide"}, rd_big, eb);
    check({req, " narrow"}, rd_small, es);
  endtask

  task automatic t_reset;
    read_chk(8'h60, "R1 low after reset");
    read_chk(8'h64, "R1 high after reset");
  endtask

  task automatic t_stopped;
    do_ticks(5);
    read_chk(8'h60, "R3 stopped count");
  endtask

  task automatic t_run;
    do_write(8'h64, 32'h0000_0100);
    do_ticks(10);
    read_chk(8'h60, "R2 ten ticks");
    repeat (6) @(negedge clk);
    read_chk(8'h60, "R2 no tick no advance");
    read_chk(8'h64, "R5 high field and run bit");
  endtask

  task automatic t_freeze;
    do_write(8'h64, 32'h0000_0000);
    do_ticks(7);
    read_chk(8'h60, "R3 frozen not cleared");
    read_chk(8'h64, "R3 run bit cleared");
  endtask

  task automatic t_ignored;
    do_write(8'h60, 32'hFFFF_FFFF);
    do_write(8'h64, 32'hFFFF_FEFF);
    do_ticks(3);
    read_chk(8'h60, "R6 low write and other bits ignored");
    read_chk(8'h64, "R6 run stays off");
    do_write(8'h64, 32'h0000_01FF);
    do_ticks(4);
    read_chk(8'h60, "R6 run set via bit 8 only");
    read_chk(8'h64, "R6 high shows run");
  endtask

  task automatic t_bus;
    read_chk(8'h60, "R4 low read");
    do_write(8'h64, 32'h0000_0100);
    check("R9 wide data held over write", rd_big, 32'(cnt_m & 64'hFFFF_FFFF));
    check("R9 narrow data held over write", rd_small, 32'(cnt_m & 64'hFF));
    read_chk(8'h10, "R9 unmapped offset");
    read_chk(8'h64, "R7 high after low via shadow");
  endtask

  task automatic t_shadow;
    do_ticks(int'(255 - cnt_m));
    read_chk(8'h60, "R7 low at 0xFF");
    do_ticks(1);
    read_chk(8'h64, "R7 high returns shadow");
    read_chk(8'h64, "R7 second high returns live");
  endtask

  task automatic t_wrap;
    do_ticks(int'(4096 - (cnt_m % 4096)));
    read_chk(8'h60, "R8 wrap low");
    read_chk(8'h64, "R8 wrap high");
    do_ticks(2);
    read_chk(8'h60, "R8 counts on after wrap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_run();
    t_freeze();
    t_ignored();
    t_bus();
    t_shadow();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule